// File: doc/BRIEF.md
# Descriptor-Driven Staged Copy Channel

This block is one bus-mastering copy engine. Software points it at a four-word descriptor in memory and arms it. Once started, the channel reads that descriptor, then copies the requested number of 32-bit words from a source region to a destination region. The copy runs in alternating steps: a read burst fills an eight-word staging store, and a write burst empties it. The steps repeat until no words remain. At the end the channel writes the descriptor's status word back with a completion flag set, and pulses a done output.

A run starts in one of two ways. Software can write the enable and go bits together. Alternatively, with enable already set, a peripheral can assert its request line. The bus side is a pipelined master with address and data phases, incrementing bursts and slave wait states. Addresses must be word aligned. Descriptor layout, by word offset from the pointer: 0 source address, 1 destination address, 2 byte count, 3 status.

Top module: `dma_chan`

## Requirements
- R1: After reset the channel is idle: `busy_o`, `done_o` and `err_o` are 0 and `htrans_o` is IDLE (2'b00).
- R2: A write to the control register (`reg_sel_i`=0) with bit 0 (enable) and bit 1 (go) both set starts a run. A go bit written without enable is not kept and never starts a run.
- R3: A high `req_i` starts a run only while the enable bit is set. With enable clear it has no effect.
- R4: Each run first reads the descriptor at the pointer register (`reg_sel_i`=1) in one four-beat burst, with `hburst_o`=3'b011.
- R5: For a byte count L, destination words 0..L/4-1 receive the matching source words, and the word after the block is not written.
- R6: Data moves in read bursts of min(8, remaining) beats. Each read burst is followed by a write burst of the same length before the next read.
- R7: After the last write burst, one single-beat write stores the status word with bit 31 set and the other bits unchanged at pointer+12.
- R8: Completion raises `done_o` for exactly one cycle and clears go. The channel then stays idle, but enable stays set, so a later `req_i` alone restarts it.
- R9: An error response (`hresp_i`=1 with `hready_i`=1) on any beat ends the run without a done pulse or a status write-back and sets a sticky `err_o`. A control write with bit 2 set clears `err_o`.
- R10: A byte count of 0 gives no data bursts: only the descriptor fetch and the status write-back occur.
- R11: While `hready_i` is low and a transfer is presented, address and transfer type hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: control, 1: descriptor pointer |
| reg_wdata_i | input | 32 | Register write data |
| req_i | input | 1 | Peripheral start request |
| haddr_o | output | 32 | Bus address |
| htrans_o | output | 2 | Transfer type (IDLE/NONSEQ/SEQ) |
| hwrite_o | output | 1 | Write transfer |
| hsize_o | output | 3 | Transfer size, always word |
| hburst_o | output | 3 | Burst type |
| hwdata_o | output | 32 | Write data |
| hrdata_i | input | 32 | Read data |
| hready_i | input | 1 | Slave ready |
| hresp_i | input | 1 | Slave error response |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky bus error flag |
| busy_o | output | 1 | Channel active |

## Verification
Byte counts of 0, 4, 32, 36 and 100 bytes, plus random multiples of four, test the burst chunking. They separate three cases: the empty run, a run shorter than the buffer, and a run that leaves a partial final chunk. Each run is checked against a burst sequence and memory image that the bench computes itself. Runs are tried with zero-wait and random-wait slaves, which shows whether the channel holds addresses during stalls. All three start paths are used: software go, enable then request, and request alone after a finished run. Negative cases cover go without enable and a request while disabled. An error injected on a source beat must end the run without a write-back.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_WBACK, ST_DONE, ST_ERROR
  } dma_state_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
  localparam logic [2:0] BURST_INCR  = 3'b001;
  localparam logic [2:0] BURST_INCR4 = 3'b011;
  localparam logic [2:0] SIZE_WORD   = 3'b010;
  localparam int DESC_WORDS = 4;
  localparam int DONE_BIT   = 31;
endpackage

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/dma_beat_ctr.sv
module dma_beat_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hready_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             issue_o,
  output logic             dp_valid_o,
  output logic [CNT_W-1:0] aidx_o,
  output logic [CNT_W-1:0] didx_o,
  output logic             last_o
);
  logic [CNT_W-1:0] aidx_q, didx_q;
  logic             dpv_q;

  assign issue_o    = aidx_q < n_i;
  assign dp_valid_o = dpv_q;
  assign aidx_o     = aidx_q;
  assign didx_o     = didx_q;
  assign last_o     = dpv_q & hready_i & (didx_q == n_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aidx_q <= '0;
      didx_q <= '0;
      dpv_q  <= 1'b0;
    end else if (clr_i) begin
      aidx_q <= '0;
      didx_q <= '0;
      dpv_q  <= 1'b0;
    end else if (hready_i) begin
      if (issue_o) aidx_q <= aidx_q + 1'b1;
      if (dpv_q)   didx_q <= didx_q + 1'b1;
      dpv_q <= issue_o;
    end
  end

  assert_beat_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (didx_q <= aidx_q) && (aidx_q <= n_i || n_i == '0));
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              req_i,
  output logic [ADDR_W-1:0] haddr_o,
  output logic [1:0]        htrans_o,
  output logic              hwrite_o,
  output logic [2:0]        hsize_o,
  output logic [2:0]        hburst_o,
  output logic [DATA_W-1:0] hwdata_o,
  input  logic [DATA_W-1:0] hrdata_i,
  input  logic              hready_i,
  input  logic              hresp_i,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o
);
  import dma_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;
  localparam int REM_W = DATA_W - 2;

  dma_state_e state_q, state_d;
  logic en_q, go_q, err_q;
  logic [ADDR_W-1:0] ptr_q, src_q, dst_q;
  logic [DATA_W-1:0] len_q, stat_q;
  logic [REM_W-1:0]  rem_q;

  logic [CNT_W-1:0] phase_n, chunk, aidx, didx;
  logic [ADDR_W-1:0] base;
  logic issue, dpv, last, beat_ok, bus_err, clr;
  logic [DATA_W-1:0] buf_rdata;

  assign chunk   = (rem_q > REM_W'(DEPTH)) ? CNT_W'(DEPTH) : rem_q[CNT_W-1:0];
  assign beat_ok = dpv & hready_i;
  assign bus_err = beat_ok & hresp_i;
  assign clr     = state_d != state_q;

  always_comb begin
    phase_n = '0;
    base    = '0;
    case (state_q)
      ST_FETCH: begin phase_n = CNT_W'(DESC_WORDS); base = ptr_q; end
      ST_READ:  begin phase_n = chunk; base = src_q; end
      ST_WRITE: begin phase_n = chunk; base = dst_q; end
      ST_WBACK: begin phase_n = CNT_W'(1); base = ptr_q + ADDR_W'(12); end
      default: ;
    endcase
  end

  dma_beat_ctr #(.CNT_W(CNT_W)) u_beats (
    .clk_i, .rst_ni, .clr_i(clr), .hready_i, .n_i(phase_n),
    .issue_o(issue), .dp_valid_o(dpv), .aidx_o(aidx), .didx_o(didx), .last_o(last)
  );

  dma_stage_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_stage (
    .clk_i,
    .we_i   (state_q == ST_READ && beat_ok && !hresp_i),
    .widx_i (didx[IDX_W-1:0]),
    .wdata_i(hrdata_i),
    .ridx_i (didx[IDX_W-1:0]),
    .rdata_o(buf_rdata)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (en_q && (go_q || req_i)) state_d = ST_FETCH;
      ST_FETCH: if (bus_err) state_d = ST_ERROR;
                else if (last) state_d = (len_q[DATA_W-1:2] == '0) ? ST_WBACK : ST_READ;
      ST_READ:  if (bus_err) state_d = ST_ERROR;
                else if (last) state_d = ST_WRITE;
      ST_WRITE: if (bus_err) state_d = ST_ERROR;
                else if (last) state_d = (rem_q == REM_W'(chunk)) ? ST_WBACK : ST_READ;
      ST_WBACK: if (bus_err) state_d = ST_ERROR;
                else if (last) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      en_q <= 1'b0; go_q <= 1'b0; err_q <= 1'b0;
      ptr_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; stat_q <= '0; rem_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FETCH && beat_ok && !hresp_i) begin
        case (didx[1:0])
          2'd0: src_q  <= hrdata_i;
          2'd1: dst_q  <= hrdata_i;
          2'd2: len_q  <= hrdata_i;
          default: stat_q <= hrdata_i;
        endcase
        if (last) rem_q <= len_q[DATA_W-1:2];
      end
      if (state_q == ST_READ && last && !hresp_i)
        src_q <= src_q + {{(ADDR_W-CNT_W-2){1'b0}}, chunk, 2'b00};
      if (state_q == ST_WRITE && last && !hresp_i) begin
        dst_q <= dst_q + {{(ADDR_W-CNT_W-2){1'b0}}, chunk, 2'b00};
        rem_q <= rem_q - REM_W'(chunk);
      end
      if (state_q == ST_DONE) go_q <= 1'b0;
      if (state_q == ST_ERROR) begin
        go_q  <= 1'b0;
        err_q <= 1'b1;
      end
      // software writes take priority over completion bookkeeping
      if (reg_we_i) begin
        if (reg_sel_i) ptr_q <= reg_wdata_i;
        else begin
          en_q <= reg_wdata_i[0];
          go_q <= reg_wdata_i[1] & reg_wdata_i[0];
          if (reg_wdata_i[2]) err_q <= 1'b0;
        end
      end
    end
  end

  assign htrans_o = (issue && !bus_err) ? ((aidx == '0) ? TR_NONSEQ : TR_SEQ) : TR_IDLE;
  assign haddr_o  = base + {{(ADDR_W-CNT_W-2){1'b0}}, aidx, 2'b00};
  assign hwrite_o = (state_q == ST_WRITE) || (state_q == ST_WBACK);
  assign hsize_o  = SIZE_WORD;
  assign hburst_o = (state_q == ST_FETCH) ? BURST_INCR4 : BURST_INCR;
  assign hwdata_o = (state_q == ST_WRITE) ? buf_rdata :
                    (state_q == ST_WBACK) ? (stat_q | (DATA_W'(1) << DONE_BIT)) : '0;
  assign done_o   = state_q == ST_DONE;
  assign err_o    = err_q;
  assign busy_o   = state_q != ST_IDLE;

  assert_bus_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o != TR_IDLE && !hready_i) |=> ($stable(haddr_o) && $stable(htrans_o)));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_wback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q == ST_WBACK));
  assert_err_no_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !done_o);
  assert_fetch_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && $past(state_q) != ST_READ) |-> $past(state_q) inside {ST_FETCH, ST_WRITE});
endmodule

// File: tb/dma_chan_test.sv
module dma_chan_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, reg_we, reg_sel, req, hready, hresp;
  logic [31:0] reg_wdata, haddr, hwdata, hrdata;
  logic [1:0] htrans;
  logic hwrite, done, err, busy;
  logic [2:0] hsize, hburst;

  dma_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .req_i(req), .haddr_o(haddr), .htrans_o(htrans),
    .hwrite_o(hwrite), .hsize_o(hsize), .hburst_o(hburst), .hwdata_o(hwdata),
    .hrdata_i(hrdata), .hready_i(hready), .hresp_i(hresp),
    .done_o(done), .err_o(err), .busy_o(busy)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [1024];
  logic dp_act = 1'b0, dp_wr = 1'b0;
  logic [9:0] dp_idx = '0;
  logic rnd_wait = 1'b0, err_en = 1'b0;
  logic [9:0] err_idx = '0;
  int bl[$]; bit bw[$]; logic [2:0] bb[$];
  int cur_len = 0; bit cur_wr; logic [2:0] cur_bt;
  int done_cnt = 0, hold_viol = 0;
  logic prev_stall = 1'b0; logic [31:0] prev_addr; logic [1:0] prev_trans;

  assign hrdata = mem[dp_idx];
  assign hresp  = dp_act && err_en && (dp_idx == err_idx) && hready;

  always @(negedge clk) hready <= rnd_wait ? ($urandom_range(3) != 0) : 1'b1;

  always @(posedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (prev_stall && (haddr != prev_addr || htrans != prev_trans)) hold_viol++;
      prev_stall <= htrans[1] && !hready;
      prev_addr  <= haddr;
      prev_trans <= htrans;
      if (hready) begin
        if (dp_act && dp_wr) mem[dp_idx] = hwdata;
        dp_act <= htrans[1];
        dp_wr  <= hwrite;
        dp_idx <= haddr[11:2];
        if (htrans == 2'b10) begin
          if (cur_len > 0) begin bl.push_back(cur_len); bw.push_back(cur_wr); bb.push_back(cur_bt); end
          cur_len = 1; cur_wr = hwrite; cur_bt = hburst;
        end else if (htrans == 2'b11) cur_len++;
      end
    end
  end

  task automatic chk(bit ok, string rq, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic flush();
    if (cur_len > 0) begin bl.push_back(cur_len); bw.push_back(cur_wr); bb.push_back(cur_bt); end
    cur_len = 0;
  endtask

  task automatic reg_write(bit sel, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle_check(string rq, int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, rq, seen, 0);
  endtask

  // mode 0: software go, 1: enable then request, 2: request only
  task automatic run_job(int src_w, int dst_w, int len_b, int mode, bit exp_err);
    int words = len_b / 4;
    int t = 0, bad = 0, rem, k, nb;
    logic [31:0] stat = $urandom & 32'h7fff_ffff;
    for (int i = 0; i < words; i++) mem[src_w + i] = $urandom;
    for (int i = 0; i <= words; i++) mem[dst_w + i] = 32'hdead_0000 + i;
    mem[0] = src_w * 4; mem[1] = dst_w * 4; mem[2] = len_b; mem[3] = stat;
    bl.delete(); bw.delete(); bb.delete(); cur_len = 0; done_cnt = 0;
    reg_write(1'b1, 32'h0);
    if (mode == 0) reg_write(1'b0, 32'h3);
    else if (mode == 1) begin reg_write(1'b0, 32'h1); pulse_req(); end
    else pulse_req();
    while (!busy && t < 20) begin @(negedge clk); t++; end
    chk(busy == 1'b1, mode == 0 ? "R2" : "R3", busy, 1);
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    flush();
    if (exp_err) begin
      chk(err == 1'b1, "R9", err, 1);
      chk(done_cnt == 0, "R9", done_cnt, 0);
      chk(mem[3] == stat, "R9", mem[3], stat);
      return;
    end
    for (int i = 0; i < words; i++) if (mem[dst_w + i] != mem[src_w + i]) bad++;
    chk(bad == 0, "R5", bad, 0);
    chk(mem[dst_w + words] == 32'hdead_0000 + words, "R5", mem[dst_w + words], 32'hdead_0000 + words);
    chk(mem[3] == (stat | 32'h8000_0000), "R7", mem[3], stat | 32'h8000_0000);
    chk(done_cnt == 1, "R8", done_cnt, 1);
    nb = 2 + 2 * ((words + 7) / 8);
    chk(bl.size() == nb, words == 0 ? "R10" : "R6", bl.size(), nb);
    if (bl.size() == nb) begin
      chk(bl[0] == 4 && !bw[0] && bb[0] == 3'b011, "R4", bl[0], 4);
      rem = words; bad = 0; k = 1;
      while (rem > 0) begin
        int c = rem > 8 ? 8 : rem;
        if (bl[k] != c || bw[k] || bl[k+1] != c || !bw[k+1]) bad++;
        rem -= c; k += 2;
      end
      chk(bad == 0, "R6", bad, 0);
      chk(bl[k] == 1 && bw[k], "R7", bl[k], 1);
    end
    idle_check("R8", 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0; req = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R1", {busy, done, err}, 0);
    chk(htrans == 2'b00, "R1", htrans, 0);

    reg_write(1'b1, 32'h0);
    reg_write(1'b0, 32'h2);
    idle_check("R2", 10);
    reg_write(1'b0, 32'h1);
    idle_check("R2", 10);
    reg_write(1'b0, 32'h0);
    pulse_req();
    idle_check("R3", 10);

    run_job(64, 512, 32, 0, 0);
    run_job(64, 512, 0, 0, 0);
    run_job(80, 600, 4, 1, 0);
    run_job(96, 640, 36, 2, 0);
    rnd_wait = 1'b1;
    run_job(64, 512, 100, 0, 0);
    for (int j = 0; j < 6; j++)
      run_job(64 + $urandom_range(100), 512 + $urandom_range(200), $urandom_range(1, 40) * 4,
              $urandom_range(2), 0);
    chk(hold_viol == 0, "R11", hold_viol, 0);

    err_en = 1'b1; err_idx = 10'(64 + 2);
    run_job(64, 512, 40, 0, 1);
    err_en = 1'b0;
    idle_check("R9", 5);
    chk(err == 1'b1, "R9", err, 1);
    reg_write(1'b0, 32'h5);
    @(negedge clk);
    chk(err == 1'b0, "R9", err, 0);
    run_job(64, 512, 44, 2, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule